// File: doc/BRIEF.md
# Multi-Channel DMA Channel Controller

This block keeps the programming state of a bank of DMA channels and carries out the bookkeeping for each burst that a peripheral asks to move. Software programs every channel through a 32-bit register bus. Each channel has four words: a free mode word, a control/status word, a remaining byte count and a memory address. The data path is not part of this block. It only decides whether a burst may proceed, how long the burst is, and where it goes in memory.

A peripheral presents a request that names a channel, a length in bytes and a direction. The controller first wipes the three completion flags of that channel. It then compares the request with the channel's enable and direction bits. If they disagree, it marks a memory error and latches a per-channel non-maskable interrupt source bit. Otherwise it limits the length to the remaining count and issues one memory command with a valid/ready handshake. When that command is accepted, it sets the terminal-count flag and charges the transferred length against the count. While a command is outstanding, `busy` turns away further requests.

Top module: `dmac_chan_ctrl`

## Requirements
- R1: After reset every channel word reads 0, the interrupt-source word reads 0, `busy` is low and no memory command is offered.
- R2: Word k (0 mode, 1 control, 2 count, 3 address) of channel n sits at byte offset 0x100 + n*0x20 + k*8. Address bits [1:0] are ignored. Writes store all 32 bits. Read data appears with `bus_rvalid` on the cycle after `bus_rd_en`.
- R3: Offsets outside the channel words and the interrupt-source word read as 0. A write to any of them, including the interrupt-source word at 0x200 and the gaps at channel offsets with bit 2 set, changes no state.
- R4: A request is taken on a clock edge where `req_valid` is high and `busy` is low. Requests offered while `busy` is high have no effect. On acceptance, control bits 8 (terminal count), 9 (memory error) and 10 (address error) of that channel are cleared.
- R5: In the control word, bit 0 enables the channel, and bit 1 set means memory-to-device (clear means device-to-memory). If bit 0 is clear, or `req_to_mem` equals bit 1, the request fails. On failure, control bit 9 is set and bit n of the interrupt-source word (offset 0x200, also on `nmi_src`) is set. No command is issued and `busy` stays low.
- R6: A good request raises `mem_cmd_valid` and `busy` one cycle after acceptance. The command carries the channel's address word, the length min(`req_len`, count) and the request direction.
- R7: On the edge where `mem_cmd_valid` and `mem_cmd_ready` are both high, control bit 8 is set and the count drops by the issued length. `busy` falls after that edge. All other control and mode bits are preserved.
- R8: While a command waits for `mem_cmd_ready`, its address, length and direction stay stable.
- R9: Interrupt-source bits only ever get set. At most one new bit is set per cycle, and only reset clears them.
- R10: A good request on a channel whose count is 0 issues a zero-length command, sets bit 8 and leaves the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| req_valid | input | 1 | Peripheral burst request |
| req_chan | input | 3 | Requested channel |
| req_len | input | 32 | Requested length in bytes |
| req_to_mem | input | 1 | 1 = device-to-memory, 0 = memory-to-device |
| busy | output | 1 | Command outstanding; requests are not taken |
| mem_cmd_valid | output | 1 | Memory command offered |
| mem_cmd_ready | input | 1 | Memory command accepted |
| mem_cmd_addr | output | 32 | Memory address of the burst |
| mem_cmd_len | output | 32 | Clamped burst length |
| mem_cmd_to_mem | output | 1 | Direction of the burst |
| nmi_src | output | 8 | Sticky per-channel error sources |

## Verification
The bench targets requests whose length lies above, equal to and below the remaining count, plus a zero count. A design that clamped wrongly would issue the raw length or underflow the count. Both failing conditions are exercised: a disabled channel, and a direction that disagrees with bit 1. An inverted direction test would issue commands that should have been refused, or refuse good ones. Stale completion flags from earlier bursts are planted in the control word. Extra requests are offered while busy, writes go to the interrupt-source word and to gap offsets, and the ready signal is held off for several cycles. These catch flags that are not cleared, leaked requests, writable error bits and commands that drift before acceptance.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned BUS_AW    = 12;
    localparam int unsigned MAX_CH    = 8;
    localparam int unsigned CH_IDX_W  = $clog2(MAX_CH);
    localparam int unsigned CH_BASE   = 32'h100;
    localparam int unsigned CH_SPAN   = 32'h20;
    localparam int unsigned NMI_OFF   = 32'h200;

    // control word bit positions
    localparam int unsigned EN_BIT    = 0;
    localparam int unsigned M2D_BIT   = 1;
    localparam int unsigned TC_BIT    = 8;
    localparam int unsigned MERR_BIT  = 9;
    localparam int unsigned AERR_BIT  = 10;

    localparam logic [WORD_W-1:0] FLAG_MASK =
        (WORD_W'(1) << TC_BIT) | (WORD_W'(1) << MERR_BIT) | (WORD_W'(1) << AERR_BIT);

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        REG_MODE  = 2'd0,
        REG_CTRL  = 2'd1,
        REG_COUNT = 2'd2,
        REG_ADDR  = 2'd3
    } reg_idx_e;

    typedef struct packed {
        word_t addr;
        word_t count;
        word_t ctrl;
        word_t mode;
    } chan_regs_t;

    typedef struct packed {
        logic                hit;
        logic [CH_IDX_W-1:0] ch;
        reg_idx_e            idx;
    } chan_dec_t;

    typedef enum logic {
        ENG_IDLE  = 1'b0,
        ENG_ISSUE = 1'b1
    } eng_state_e;

    function automatic chan_dec_t f_decode(input logic [BUS_AW-1:0] a,
                                           input int unsigned nch);
        chan_dec_t   d;
        logic [31:0] off;
        off   = 32'(a) - CH_BASE;
        d.hit = (32'(a) >= CH_BASE) && (off < nch * CH_SPAN) && (a[2] == 1'b0);
        d.ch  = off[5 +: CH_IDX_W];
        d.idx = reg_idx_e'(off[4:3]);
        return d;
    endfunction

    function automatic word_t f_clamp(input word_t want, input word_t avail);
        return (want > avail) ? avail : want;
    endfunction

    function automatic word_t f_start_flags(input word_t ctrl, input logic fail);
        word_t v;
        v = ctrl & ~FLAG_MASK;
        v[MERR_BIT] = fail;
        return v;
    endfunction

endpackage

// File: rtl/dmac_regbank.sv
module dmac_regbank
    import dmac_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [BUS_AW-1:0]          wr_addr,
    input  word_t                      wr_data,
    input  logic                       eng_ctrl_we,
    input  logic                       eng_count_we,
    input  logic [CH_IDX_W-1:0]        eng_ch,
    input  word_t                      eng_ctrl_val,
    input  word_t                      eng_count_val,
    output chan_regs_t [NUM_CH-1:0]    regs_o
);

    chan_dec_t wdec;
    assign wdec = f_decode(wr_addr, NUM_CH);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [CH_IDX_W-1:0] CID = CH_IDX_W'(c);
        logic bus_sel;
        logic eng_sel;
        assign bus_sel = wr_en && wdec.hit && (wdec.ch == CID);
        assign eng_sel = (eng_ch == CID);

        always_ff @(posedge clk) begin
            if (rst) begin
                regs_o[c] <= '0;
            end else begin
                if (bus_sel && wdec.idx == REG_MODE)
                    regs_o[c].mode <= wr_data;
                if (bus_sel && wdec.idx == REG_ADDR)
                    regs_o[c].addr <= wr_data;
                // engine updates take priority over a same-cycle bus write
                if (eng_ctrl_we && eng_sel)
                    regs_o[c].ctrl <= eng_ctrl_val;
                else if (bus_sel && wdec.idx == REG_CTRL)
                    regs_o[c].ctrl <= wr_data;
                if (eng_count_we && eng_sel)
                    regs_o[c].count <= eng_count_val;
                else if (bus_sel && wdec.idx == REG_COUNT)
                    regs_o[c].count <= wr_data;
            end
        end
    end

endmodule

// File: rtl/dmac_rdport.sv
module dmac_rdport
    import dmac_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rd_en,
    input  logic [BUS_AW-1:0]       rd_addr,
    input  chan_regs_t [NUM_CH-1:0] regs_i,
    input  logic [NUM_CH-1:0]       nmi_i,
    output word_t                   rdata,
    output logic                    rvalid
);

    chan_dec_t  rdec;
    chan_regs_t sel;
    word_t      nxt;

    assign rdec = f_decode(rd_addr, NUM_CH);

    always_comb begin
        sel = '0;
        for (int c = 0; c < NUM_CH; c++)
            if (rdec.ch == CH_IDX_W'(c)) sel = regs_i[c];
        nxt = '0;
        if (rdec.hit) begin
            unique case (rdec.idx)
                REG_MODE:  nxt = sel.mode;
                REG_CTRL:  nxt = sel.ctrl;
                REG_COUNT: nxt = sel.count;
                REG_ADDR:  nxt = sel.addr;
            endcase
        end else if ({rd_addr[BUS_AW-1:2], 2'b00} == BUS_AW'(NMI_OFF)) begin
            nxt = WORD_W'(nmi_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) rdata <= nxt;
        end
    end

endmodule

// File: rtl/dmac_burst_eng.sv
module dmac_burst_eng
    import dmac_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [CH_IDX_W-1:0]     req_chan,
    input  word_t                   req_len,
    input  logic                    req_to_mem,
    input  chan_regs_t [NUM_CH-1:0] regs_i,
    output logic                    busy,
    output logic                    cmd_valid,
    input  logic                    cmd_ready,
    output word_t                   cmd_addr,
    output word_t                   cmd_len,
    output logic                    cmd_to_mem,
    output logic                    eng_ctrl_we,
    output logic                    eng_count_we,
    output logic [CH_IDX_W-1:0]     eng_ch,
    output word_t                   eng_ctrl_val,
    output word_t                   eng_count_val,
    output logic [NUM_CH-1:0]       nmi_o
);

    eng_state_e          state;
    logic [CH_IDX_W-1:0] cur_ch;
    chan_regs_t          req_regs;
    chan_regs_t          cur_regs;
    logic                take;
    logic                fail;
    logic                done;

    always_comb begin
        req_regs = '0;
        cur_regs = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (req_chan == CH_IDX_W'(c)) req_regs = regs_i[c];
            if (cur_ch   == CH_IDX_W'(c)) cur_regs = regs_i[c];
        end
    end

    assign take = req_valid && (state == ENG_IDLE) && (32'(req_chan) < NUM_CH);
    // request direction must be the opposite of the memory-to-device bit
    assign fail = !req_regs.ctrl[EN_BIT] || (req_to_mem == req_regs.ctrl[M2D_BIT]);
    assign done = (state == ENG_ISSUE) && cmd_ready;

    assign busy      = (state == ENG_ISSUE);
    assign cmd_valid = (state == ENG_ISSUE);

    always_comb begin
        eng_ctrl_we   = take || done;
        eng_count_we  = done;
        eng_ch        = take ? req_chan : cur_ch;
        eng_ctrl_val  = take ? f_start_flags(req_regs.ctrl, fail)
                             : (cur_regs.ctrl | (WORD_W'(1) << TC_BIT));
        eng_count_val = cur_regs.count - cmd_len;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ENG_IDLE;
            cur_ch     <= '0;
            cmd_addr   <= '0;
            cmd_len    <= '0;
            cmd_to_mem <= 1'b0;
            nmi_o      <= '0;
        end else begin
            unique case (state)
                ENG_IDLE: begin
                    if (take && fail) begin
                        nmi_o[req_chan] <= 1'b1;
                    end else if (take) begin
                        state      <= ENG_ISSUE;
                        cur_ch     <= req_chan;
                        cmd_addr   <= req_regs.addr;
                        cmd_len    <= f_clamp(req_len, req_regs.count);
                        cmd_to_mem <= req_to_mem;
                    end
                end
                ENG_ISSUE: begin
                    if (cmd_ready) state <= ENG_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/dmac_chan_ctrl.sv
module dmac_chan_ctrl
    import dmac_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr_en,
    input  logic                  bus_rd_en,
    input  logic [BUS_AW-1:0]     bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    output logic                  bus_rvalid,
    input  logic                  req_valid,
    input  logic [CH_IDX_W-1:0]   req_chan,
    input  logic [WORD_W-1:0]     req_len,
    input  logic                  req_to_mem,
    output logic                  busy,
    output logic                  mem_cmd_valid,
    input  logic                  mem_cmd_ready,
    output logic [WORD_W-1:0]     mem_cmd_addr,
    output logic [WORD_W-1:0]     mem_cmd_len,
    output logic                  mem_cmd_to_mem,
    output logic [NUM_CH-1:0]     nmi_src
);

    chan_regs_t [NUM_CH-1:0] regs;
    logic                    e_ctrl_we;
    logic                    e_count_we;
    logic [CH_IDX_W-1:0]     e_ch;
    word_t                   e_ctrl_val;
    word_t                   e_count_val;

    dmac_regbank #(.NUM_CH(NUM_CH)) u_bank (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (bus_wr_en),
        .wr_addr       (bus_addr),
        .wr_data       (bus_wdata),
        .eng_ctrl_we   (e_ctrl_we),
        .eng_count_we  (e_count_we),
        .eng_ch        (e_ch),
        .eng_ctrl_val  (e_ctrl_val),
        .eng_count_val (e_count_val),
        .regs_o        (regs)
    );

    dmac_burst_eng #(.NUM_CH(NUM_CH)) u_eng (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_chan      (req_chan),
        .req_len       (req_len),
        .req_to_mem    (req_to_mem),
        .regs_i        (regs),
        .busy          (busy),
        .cmd_valid     (mem_cmd_valid),
        .cmd_ready     (mem_cmd_ready),
        .cmd_addr      (mem_cmd_addr),
        .cmd_len       (mem_cmd_len),
        .cmd_to_mem    (mem_cmd_to_mem),
        .eng_ctrl_we   (e_ctrl_we),
        .eng_count_we  (e_count_we),
        .eng_ch        (e_ch),
        .eng_ctrl_val  (e_ctrl_val),
        .eng_count_val (e_count_val),
        .nmi_o         (nmi_src)
    );

    dmac_rdport #(.NUM_CH(NUM_CH)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (bus_rd_en),
        .rd_addr (bus_addr),
        .regs_i  (regs),
        .nmi_i   (nmi_src),
        .rdata   (bus_rdata),
        .rvalid  (bus_rvalid)
    );

endmodule

// File: rtl/dmac_chan_ctrl_chk.sv
module dmac_chan_ctrl_chk #(
    parameter int unsigned NUM_CH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic [31:0]       req_len,
    input logic              mem_cmd_valid,
    input logic              mem_cmd_ready,
    input logic [31:0]       mem_cmd_addr,
    input logic [31:0]       mem_cmd_len,
    input logic              mem_cmd_to_mem,
    input logic [NUM_CH-1:0] nmi_src
);

    // R6: an issued length never exceeds what was asked for
    a_r6_len_clamped: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_cmd_valid) |-> (mem_cmd_len <= $past(req_len)));

    // R8: a waiting command holds still
    a_r8_cmd_stable: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd_valid && !mem_cmd_ready) |=>
            (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_len)
             && $stable(mem_cmd_to_mem)));

    // R7: acceptance releases busy
    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd_valid && mem_cmd_ready) |=> !busy);

    // R9: error sources never clear
    a_r9_nmi_sticky: assert property (@(posedge clk) disable iff (rst)
        ((nmi_src & $past(nmi_src)) == $past(nmi_src)));

    // R9: at most one new error source per cycle
    a_r9_one_new: assert property (@(posedge clk) disable iff (rst)
        $onehot0(nmi_src & ~$past(nmi_src)));

    // R5: a fresh error source comes with no command
    a_r5_err_no_cmd: assert property (@(posedge clk) disable iff (rst)
        (nmi_src != $past(nmi_src)) |-> !mem_cmd_valid);

endmodule

bind dmac_chan_ctrl dmac_chan_ctrl_chk #(.NUM_CH(NUM_CH)) i_chk (
    .clk            (clk),
    .rst            (rst),
    .busy           (busy),
    .req_len        (req_len),
    .mem_cmd_valid  (mem_cmd_valid),
    .mem_cmd_ready  (mem_cmd_ready),
    .mem_cmd_addr   (mem_cmd_addr),
    .mem_cmd_len    (mem_cmd_len),
    .mem_cmd_to_mem (mem_cmd_to_mem),
    .nmi_src        (nmi_src)
);

// File: tb/test_dmac_chan_ctrl.sv
`timescale 1ns/1ps
module test_dmac_chan_ctrl;

    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr_en, bus_rd_en;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_rvalid;
    logic        req_valid;
    logic [2:0]  req_chan;
    logic [31:0] req_len;
    logic        req_to_mem;
    logic        busy, mem_cmd_valid, mem_cmd_ready, mem_cmd_to_mem;
    logic [31:0] mem_cmd_addr, mem_cmd_len;
    logic [7:0]  nmi_src;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [31:0] mdl [NCH*4];
    logic [7:0]  mdl_nmi;

    dmac_chan_ctrl #(.NUM_CH(NCH)) i_dmac_chan_ctrl (.*);

    always #5 clk = ~clk;

    function automatic logic [11:0] f_off(input int ch, input int k);
        return 12'(32'h100 + ch * 32'h20 + k * 8);
    endfunction

    function automatic logic [31:0] f_min(input logic [31:0] a, input logic [31:0] b);
        return (a > b) ? b : a;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
        chk("R2 rvalid", 32'(bus_rvalid), 32'd1);
        d = bus_rdata;
    endtask

    task automatic prog(input int ch, input logic [31:0] m, input logic [31:0] c,
                        input logic [31:0] n, input logic [31:0] a);
        wr(f_off(ch, 0), m); mdl[ch*4+0] = m;
        wr(f_off(ch, 1), c); mdl[ch*4+1] = c;
        wr(f_off(ch, 2), n); mdl[ch*4+2] = n;
        wr(f_off(ch, 3), a); mdl[ch*4+3] = a;
    endtask

    task automatic check_chan(input string tag, input int ch);
        logic [31:0] v;
        for (int k = 0; k < 4; k++) begin
            rd(f_off(ch, k), v);
            chk(tag, v, mdl[ch*4+k]);
        end
    endtask

    // one request with the given ready delay; extra requests offered while busy if poke
    task automatic request(input int ch, input logic [31:0] len, input logic tomem,
                           input int delay, input bit poke);
        logic [31:0] ctrl, cnt, ilen;
        bit          bad;
        ctrl = mdl[ch*4+1];
        cnt  = mdl[ch*4+2];
        bad  = !ctrl[0] || (tomem == ctrl[1]);
        ilen = f_min(len, cnt);
        @(negedge clk);
        req_valid = 1'b1; req_chan = 3'(ch); req_len = len; req_to_mem = tomem;
        @(negedge clk);
        req_valid = 1'b0;
        if (bad) begin
            mdl[ch*4+1] = (ctrl & ~32'h700) | 32'h200;
            mdl_nmi[ch] = 1'b1;
            chk("R5 no cmd", 32'(mem_cmd_valid), 32'd0);
            chk("R5 busy low", 32'(busy), 32'd0);
            chk("R5 nmi", 32'(nmi_src), 32'(mdl_nmi));
        end else begin
            chk("R6 valid", 32'(mem_cmd_valid), 32'd1);
            chk("R6 busy", 32'(busy), 32'd1);
            chk("R6 addr", mem_cmd_addr, mdl[ch*4+3]);
            chk("R6 len", mem_cmd_len, ilen);
            chk("R6 dir", 32'(mem_cmd_to_mem), 32'(tomem));
            for (int i = 0; i < delay; i++) begin
                if (poke && i < 2) begin
                    // R4: a request while busy on another channel must be dropped
                    req_valid = 1'b1; req_chan = 3'((ch + 1) % NCH);
                    req_to_mem = ~req_to_mem;
                end
                @(negedge clk);
                req_valid = 1'b0;
                chk("R8 held valid", 32'(mem_cmd_valid), 32'd1);
                chk("R8 held len", mem_cmd_len, ilen);
                chk("R8 held addr", mem_cmd_addr, mdl[ch*4+3]);
            end
            mem_cmd_ready = 1'b1;
            @(negedge clk);
            mem_cmd_ready = 1'b0;
            chk("R7 busy released", 32'(busy), 32'd0);
            chk("R4 nmi untouched", 32'(nmi_src), 32'(mdl_nmi));
            mdl[ch*4+1] = (ctrl & ~32'h700) | 32'h100;
            mdl[ch*4+2] = cnt - ilen;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        void'($urandom(32'h5eed_0042));
        bus_wr_en = 0; bus_rd_en = 0; bus_addr = 0; bus_wdata = 0;
        req_valid = 0; req_chan = 0; req_len = 0; req_to_mem = 0;
        mem_cmd_ready = 0;
        for (int i = 0; i < NCH*4; i++) mdl[i] = '0;
        mdl_nmi = '0;
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 cmd", 32'(mem_cmd_valid), 32'd0);
        chk("R1 nmi", 32'(nmi_src), 32'd0);
        for (int c = 0; c < NCH; c++) check_chan("R1 regs", c);
        rd(12'h200, v); chk("R1 nmi word", v, 32'd0);

        // R2 map with ignored low bits, R3 gaps and unmapped
        wr(12'h10B, 32'hDEAD_BEE0); mdl[1] = 32'hDEAD_BEE0;
        wr(12'h1EC, 32'h1234_5678);
        wr(12'h104, 32'hFFFF_FFFF);
        wr(12'h200, 32'h0000_00FF);
        wr(12'h050, 32'hAAAA_5555);
        check_chan("R2 ch0", 0);
        check_chan("R3 ch7", 7);
        rd(12'h104, v); chk("R3 gap read", v, 32'd0);
        rd(12'h050, v); chk("R3 unmapped read", v, 32'd0);
        rd(12'h200, v); chk("R3 nmi write ignored", v, 32'd0);

        // R5 disabled channel, with stale flags planted
        prog(2, 32'h55, 32'h0000_0702, 32'd100, 32'h8000_0000);
        request(2, 32'd10, 1'b0, 0, 0);
        check_chan("R5 disabled", 2);
        // R5 direction mismatch: memory-to-device channel asked for to-memory
        prog(3, 32'h0, 32'h0000_0503, 32'd50, 32'h1000);
        request(3, 32'd8, 1'b1, 0, 0);
        check_chan("R5 mismatch", 3);
        rd(12'h200, v); chk("R9 nmi word", v, 32'(mdl_nmi));

        // R6/R7 clamp above count, with a delayed ready and a request while busy (R4)
        prog(4, 32'hA5, 32'h0000_0701, 32'd64, 32'h0002_0000);
        request(4, 32'd200, 1'b1, 4, 1);
        check_chan("R7 clamp high", 4);
        // length below remaining count
        prog(5, 32'h0, 32'h0000_0003, 32'd300, 32'h0003_0040);
        request(5, 32'd17, 1'b0, 1, 0);
        check_chan("R7 clamp low", 5);
        // equal to remaining count, then R10 zero count
        request(5, 32'd283, 1'b0, 0, 0);
        check_chan("R7 exact", 5);
        request(5, 32'd9, 1'b0, 2, 0);
        check_chan("R10 zero count", 5);

        // random mix
        for (int it = 0; it < 60; it++) begin
            int          ch;
            logic [31:0] ctrl;
            ch   = int'($urandom_range(0, NCH-1));
            ctrl = $urandom() & 32'hFFFF_F7FF;
            if ($urandom_range(0, 3) != 0) ctrl[0] = 1'b1;
            if ($urandom_range(0, 1) == 0)
                prog(ch, $urandom(), ctrl, $urandom_range(0, 300), $urandom());
            request(ch, $urandom_range(0, 400), 1'($urandom_range(0, 1)),
                    int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
            check_chan("R4 R6 R7 random", ch);
        end
        rd(12'h200, v); chk("R9 final nmi", v, 32'(mdl_nmi));
        chk("R9 nmi port", 32'(nmi_src), 32'(mdl_nmi));

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule